// File: doc/BRIEF.md
# MSI Request Generator with Vector Folding

This block sits between the interrupt sources of an application and the message-signaled interrupt port of a PCIe endpoint's transaction layer. A source raises a one-cycle request that carries a 5-bit vector and a 3-bit traffic class. The block folds the vector onto the number of messages the host has granted, queues the request, and issues it through a request/acknowledge handshake.

The host grants messages as a power of two, and the grant can be smaller than the count the function asked for. For example, a function can ask for 8 messages and be granted 2. The block therefore keeps only as many low vector bits as the grant allows, and clears the rest at the moment the request is queued.

When the host has left MSI disabled, no request is queued. Each request instead sets a sticky legacy interrupt status bit, which the application clears. The queue is four entries deep. A request that finds the queue full is discarded, and a one-cycle overflow pulse reports the loss.

Top module: `msi_request_gen`

## Requirements
- R1: After reset, `msi_req`, `legacy_int_sts` and `overflow` are all low.
- R2: Let k be `msi_ctrl[6:4]`. When k is below 5, only the low k bits of the vector are kept in the issued `msi_num` and its upper bits are zero. When k is 5, 6 or 7, the whole vector is issued. The grant in force on the accepting clock edge applies.
- R3: The traffic class given with a request appears unchanged on `msi_tc` when that request is issued.
- R4: Once `msi_req` rises, it stays high with `msi_num` and `msi_tc` unchanged until a cycle in which `msi_ack` is high.
- R5: In the cycle after an acknowledge, `msi_req` is low. If more requests are queued, the next one rises in the cycle after that.
- R6: With the block idle and MSI enabled, a request accepted on clock edge n drives `msi_req` high after edge n+1. Requests are issued in the order they were accepted.
- R7: The queue holds 4 entries, and one more request can be in the handshake. A request with MSI enabled that arrives while all 4 entries are occupied is discarded, and `overflow` is high for exactly the following cycle.
- R8: When `msi_ctrl[0]` is 0, a request is not queued and never produces `msi_req`. Instead it sets `legacy_int_sts` from the next cycle on.
- R9: `legacy_clr` clears `legacy_int_sts`. When a disabled-mode request and `legacy_clr` arrive in the same cycle, the status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | One-cycle interrupt request strobe |
| src_vector | input | 5 | Requested vector |
| src_tclass | input | 3 | Requested traffic class |
| msi_ctrl | input | 16 | MSI control word; bit 0 enable, bits 6:4 granted count exponent |
| msi_ack | input | 1 | One-cycle acknowledge from the transaction layer |
| legacy_clr | input | 1 | Clears the legacy status |
| msi_req | output | 1 | Pending MSI request |
| msi_num | output | 5 | Folded vector of the pending request |
| msi_tc | output | 3 | Traffic class of the pending request |
| legacy_int_sts | output | 1 | Sticky legacy interrupt status |
| overflow | output | 1 | One-cycle pulse when a request is discarded |

## Verification
The checks on issued vectors compare `msi_num` against the grant field that is present while the request is pending. They therefore assume that `msi_ctrl` does not change between acceptance and acknowledge. The stimulus changes the control word only while nothing is queued or in flight. The assertions also assume that `msi_ack` is high only while `msi_req` is high, and the bench raises it only after it has seen the request.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int VEC_W = 5;
  localparam int TC_W  = 3;
  localparam int MME_W = 3;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    logic [TC_W-1:0]  tc;
  } msi_entry_t;

  localparam int ENTRY_W = $bits(msi_entry_t);

  // A bit survives when its index is below the granted exponent.
  function automatic logic [VEC_W-1:0] grant_mask(input logic [MME_W-1:0] mme);
    logic [VEC_W-1:0] m;
    for (int i = 0; i < VEC_W; i++) m[i] = (i < int'(mme));
    return m;
  endfunction
endpackage

// File: rtl/msi_vec_mask.sv
module msi_vec_mask
  import msi_pkg::*;
(
  input  logic [VEC_W-1:0] vec_in,
  input  logic [MME_W-1:0] mme,
  output logic [VEC_W-1:0] vec_out
);
  always_comb vec_out = vec_in & grant_mask(mme);
endmodule

// File: rtl/msi_req_fifo.sv
module msi_req_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rd_data = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end
endmodule

// File: rtl/msi_handshake_fsm.sv
module msi_handshake_fsm
  import msi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  msi_entry_t       q_head,
  input  logic             ack,
  output logic             q_pop,
  output logic             req,
  output logic [VEC_W-1:0] num,
  output logic [TC_W-1:0]  tc
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_GAP} hs_state_t;

  hs_state_t  state, state_nx;
  msi_entry_t hold;
  logic       load;

  // Loading from GAP gives exactly one low cycle between requests.
  assign load  = (state != S_ISSUE) && !q_empty;
  assign q_pop = load;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (load) state_nx = S_ISSUE;
      S_ISSUE: if (ack)  state_nx = S_GAP;
      S_GAP:   state_nx = load ? S_ISSUE : S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      hold  <= '0;
    end else begin
      state <= state_nx;
      if (load) hold <= q_head;
    end
  end

  assign req = (state == S_ISSUE);
  assign num = hold.vec;
  assign tc  = hold.tc;
endmodule

// File: rtl/msi_legacy_sts.sv
module msi_legacy_sts (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic sts
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sts <= 1'b0;
    else if (set_evt) sts <= 1'b1;
    else if (clr)     sts <= 1'b0;
  end
endmodule

// File: rtl/msi_request_gen.sv
module msi_request_gen
  import msi_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_valid,
  input  logic [VEC_W-1:0] src_vector,
  input  logic [TC_W-1:0]  src_tclass,
  input  logic [15:0]      msi_ctrl,
  input  logic             msi_ack,
  input  logic             legacy_clr,
  output logic             msi_req,
  output logic [VEC_W-1:0] msi_num,
  output logic [TC_W-1:0]  msi_tc,
  output logic             legacy_int_sts,
  output logic             overflow
);
  logic             msi_en;
  logic [MME_W-1:0] mme;
  logic [VEC_W-1:0] folded_vec;
  logic             fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic             drop_evt, legacy_evt;
  msi_entry_t       wr_entry, head_entry;
  logic             ctrl_unused;

  assign msi_en      = msi_ctrl[0];
  assign mme         = msi_ctrl[6:4];
  assign ctrl_unused = ^{msi_ctrl[15:7], msi_ctrl[3:1]};

  assign fifo_push  = src_valid && msi_en && !fifo_full;
  assign drop_evt   = src_valid && msi_en && fifo_full;
  assign legacy_evt = src_valid && !msi_en;

  msi_vec_mask u_mask (
    .vec_in (src_vector),
    .mme    (mme),
    .vec_out(folded_vec)
  );

  always_comb begin
    wr_entry.vec = folded_vec;
    wr_entry.tc  = src_tclass;
  end

  msi_req_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (fifo_push),
    .wr_data(wr_entry),
    .pop    (fifo_pop),
    .rd_data(head_entry),
    .full   (fifo_full),
    .empty  (fifo_empty)
  );

  msi_handshake_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .q_empty(fifo_empty),
    .q_head (head_entry),
    .ack    (msi_ack),
    .q_pop  (fifo_pop),
    .req    (msi_req),
    .num    (msi_num),
    .tc     (msi_tc)
  );

  msi_legacy_sts u_legacy (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(legacy_evt),
    .clr    (legacy_clr),
    .sts    (legacy_int_sts)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) overflow <= 1'b0;
    else        overflow <= drop_evt;
  end
endmodule

// File: rtl/msi_request_gen_chk.sv
module msi_request_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        src_valid,
  input logic [15:0] msi_ctrl,
  input logic        msi_ack,
  input logic        msi_req,
  input logic [4:0]  msi_num,
  input logic [2:0]  msi_tc,
  input logic        legacy_int_sts,
  input logic        overflow,
  input logic        fifo_full,
  input logic        fifo_push
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req && !msi_ack |=> msi_req && $stable(msi_num) && $stable(msi_tc));

  // R5
  ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req && msi_ack |=> !msi_req);

  // R2
  fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req && (msi_ctrl[6:4] < 3'd5) |-> ((msi_num >> msi_ctrl[6:4]) == 5'd0));

  // R7
  overflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(fifo_full && src_valid));

  // R8
  disabled_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> msi_ctrl[0]);

  // R8
  legacy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(legacy_int_sts) |-> $past(src_valid && !msi_ctrl[0]));
endmodule

bind msi_request_gen msi_request_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_valid     (src_valid),
  .msi_ctrl      (msi_ctrl),
  .msi_ack       (msi_ack),
  .msi_req       (msi_req),
  .msi_num       (msi_num),
  .msi_tc        (msi_tc),
  .legacy_int_sts(legacy_int_sts),
  .overflow      (overflow),
  .fifo_full     (fifo_full),
  .fifo_push     (fifo_push)
);

// File: tb/tb_msi_request_gen.sv
module tb_msi_request_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       src_valid, msi_ack, legacy_clr;
  logic [4:0] src_vector;
  logic [2:0] src_tclass;
  logic [15:0] msi_ctrl;
  logic       msi_req, legacy_int_sts, overflow;
  logic [4:0] msi_num;
  logic [2:0] msi_tc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_request_gen dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_vector(src_vector),
    .src_tclass(src_tclass), .msi_ctrl(msi_ctrl), .msi_ack(msi_ack),
    .legacy_clr(legacy_clr), .msi_req(msi_req), .msi_num(msi_num),
    .msi_tc(msi_tc), .legacy_int_sts(legacy_int_sts), .overflow(overflow)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl_word(input int k, input bit en);
    return {9'd0, 3'(k), 3'd0, en};
  endfunction

  // Expected folding: vector modulo the granted count, capped at 32.
  function automatic int fold_ref(input int v, input int k);
    int cnt = (k >= 5) ? 32 : (1 << k);
    return v % cnt;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_valid = 0; src_vector = 0; src_tclass = 0;
    msi_ctrl = ctrl_word(5, 1'b1); msi_ack = 0; legacy_clr = 0;
    repeat (3) cyc();
    // R1: reset state
    chk("R1 req", int'(msi_req), 0);
    chk("R1 legacy", int'(legacy_int_sts), 0);
    chk("R1 overflow", int'(overflow), 0);
    rst_n = 1'b1;
    cyc();

    // R2 R3 R6 R5: sweep every grant exponent and vector
    for (int k = 0; k < 8; k++) begin
      msi_ctrl = ctrl_word(k, 1'b1);
      for (int v = 0; v < 32; v++) begin
        src_valid = 1; src_vector = 5'(v); src_tclass = 3'(v ^ k);
        cyc();
        src_valid = 0;
        chk("R6 not yet", int'(msi_req), 0);
        cyc();
        chk("R6 latency", int'(msi_req), 1);
        chk("R2 fold", int'(msi_num), fold_ref(v, k));
        chk("R3 tclass", int'(msi_tc), (v ^ k) & 7);
        msi_ack = 1;
        cyc();
        msi_ack = 0;
        chk("R5 gap", int'(msi_req), 0);
        cyc();
        chk("R5 idle", int'(msi_req), 0);
      end
    end

    // R4: request held with stable payload while ack is withheld
    msi_ctrl = ctrl_word(3, 1'b1);
    src_valid = 1; src_vector = 5'd13; src_tclass = 3'd6;
    cyc(); src_valid = 0; cyc();
    for (int i = 0; i < 4; i++) begin
      chk("R4 held", int'(msi_req), 1);
      chk("R4 num", int'(msi_num), 5);
      chk("R4 tc", int'(msi_tc), 6);
      cyc();
    end
    msi_ack = 1; cyc(); msi_ack = 0;
    chk("R5 after hold", int'(msi_req), 0);
    cyc();

    // R7 R6: burst of 7 with no ack; last two are dropped
    msi_ctrl = ctrl_word(5, 1'b1);
    for (int i = 0; i < 7; i++) begin
      src_valid = 1; src_vector = 5'(i + 9); src_tclass = 3'(i);
      cyc();
      chk("R7 overflow", int'(overflow), (i >= 5) ? 1 : 0);
    end
    src_valid = 0;
    cyc();
    chk("R7 pulse ends", int'(overflow), 0);
    for (int j = 0; j < 5; j++) begin
      int w = 0;
      while (!msi_req && w < 10) begin cyc(); w++; end
      chk("R6 order num", int'(msi_num), j + 9);
      chk("R6 order tc", int'(msi_tc), j);
      msi_ack = 1; cyc(); msi_ack = 0;
      chk("R5 burst gap", int'(msi_req), 0);
      cyc();
      if (j < 4) chk("R5 next rises", int'(msi_req), 1);
    end
    for (int i = 0; i < 5; i++) begin
      chk("R7 dropped not issued", int'(msi_req), 0);
      cyc();
    end

    // R8: MSI disabled routes to legacy status
    msi_ctrl = ctrl_word(5, 1'b0);
    src_valid = 1; src_vector = 5'd7; src_tclass = 3'd1;
    cyc(); src_valid = 0;
    chk("R8 legacy set", int'(legacy_int_sts), 1);
    for (int i = 0; i < 4; i++) begin
      chk("R8 no req", int'(msi_req), 0);
      cyc();
    end
    chk("R8 legacy sticky", int'(legacy_int_sts), 1);
    // R9: clear, then set beating clear
    legacy_clr = 1; cyc(); legacy_clr = 0;
    chk("R9 cleared", int'(legacy_int_sts), 0);
    legacy_clr = 1; src_valid = 1; cyc();
    legacy_clr = 0; src_valid = 0;
    chk("R9 set wins", int'(legacy_int_sts), 1);
    legacy_clr = 1; cyc(); legacy_clr = 0;
    chk("R9 cleared again", int'(legacy_int_sts), 0);
    // R8: nothing was queued while disabled
    msi_ctrl = ctrl_word(5, 1'b1);
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R8 nothing queued", int'(msi_req), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule